// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an 8192-word by 8-bit asynchronous static RAM. The host hands over one word at a time through a valid/ready handshake, carrying a 13-bit address, a read/write flag and 8-bit write data. For each accepted request the controller produces the enable sequence the memory needs: two chip selects of opposite polarity, an active-low output enable and an active-low write enable. Read data comes back to the host with a single-cycle valid pulse.

All timing is counted in whole clock cycles. Each nanosecond limit of the memory is turned into a cycle count by rounding up against the clock period, and never drops below one. A write is the overlap of both selects and a low write enable. The controller shapes that overlap with write enable alone, and keeps the selects asserted for one more cycle so that the address and data hold past the terminating edge. The data driver toward the shared bus has its own enable output. It turns on only after output enable has been high long enough for the memory to release the bus. Between transactions the memory is deselected, which also puts it in its low-power state.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the low-active select is 1, the high-active select is 0, output enable and write enable are 1, the data driver is off, reqReady is 1 and rspValid is 0.
- R2: In every cycle where reqReady is 1 the memory is deselected (low-active select 1, high-active select 0), output enable and write enable are 1, and the data driver is off.
- R3: A word written to an address is returned unchanged by a later read of that address. This holds at address 0 and at address 8191.
- R4: During a write, write enable is 0 for exactly WR_CYC consecutive cycles, with both selects active and output enable 1. WR_CYC is the largest of the rounded-up pulse width, data setup, address setup and cycle time.
- R5: Address and write data stay at the accepted values, with the driver on, in every cycle that write enable is 0 and in the cycle after write enable returns to 1.
- R6: The data driver is on only while output enable is 1 and has been 1 for at least HZ_CYC preceding cycles. HZ_CYC is the rounded-up output-to-high-impedance time.
- R7: During a read, output enable is 0 for exactly RD_CYC consecutive cycles, with write enable 1 and the driver off. RD_CYC is the largest of the rounded-up access time, output-enable access time and cycle time. rspValid is 1 for exactly the one cycle after output enable returns to 1, and rspRdata then holds the memory's word.
- R8: A request is taken only in a cycle where reqValid and reqReady are both 1. Changes on reqAddr, reqWdata and reqWrite after that cycle do not affect the transaction under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 13 | Word address |
| reqWdata | input | 8 | Data to write |
| rspValid | output | 1 | One-cycle pulse marking returned read data |
| rspRdata | output | 8 | Last word read |
| memAddr | output | 13 | Address to the memory |
| memSelN | output | 1 | Low-active chip select |
| memSelP | output | 1 | High-active chip select |
| memOeN | output | 1 | Low-active output enable |
| memWeN | output | 1 | Low-active write enable |
| memDout | output | 8 | Data toward the shared bus |
| memDin | input | 8 | Data from the shared bus |
| dataDrvEn | output | 1 | Enable of the controller's bus driver |

## Verification
The bench builds the controller with an 8 ns clock against the slowest memory grade: 35 ns cycle, 20 ns write pulse, 12 ns data setup, 25 ns address setup, 35 ns access, 15 ns output-enable access and a 10 ns turn-off time. These values give a two-cycle turn-off wait and five-cycle write pulses and read phases, so every phase counter runs through several states instead of expiring at once. The 25 ns address setup and the 35 ns cycle time also round up by different amounts, so the bench can tell whether the maximum picks the correct limit. Reads that directly follow writes, and writes that directly follow reads, exercise the turnaround where bus contention would appear.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a newly accepted request
    logic capture;  // sample read data from the bus
    logic drive;    // enable the write-data driver
  } dp_strobe_t;

  // nanoseconds to cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int HZ_CYC = 1,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2,
  parameter int CNT_W  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       memSelN,
  output logic       memSelP,
  output logic       memOeN,
  output logic       memWeN,
  output dp_strobe_t strobe
);

  ctrl_state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic phaseDone;

  assign phaseDone = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = phaseDone ? cnt : cnt - CNT_W'(1);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext = reqWrite ? ST_WSETUP : ST_READ;
          cntNext   = reqWrite ? CNT_W'(HZ_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSETUP: begin
        if (phaseDone) begin
          stateNext = ST_WPULSE;
          cntNext   = CNT_W'(WR_CYC - 1);
        end
      end
      ST_WPULSE: if (phaseDone) stateNext = ST_WHOLD;
      ST_WHOLD:  stateNext = ST_IDLE;
      ST_READ:   if (phaseDone) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  logic selected;
  assign selected = (state != ST_IDLE);
  assign reqReady = (state == ST_IDLE);
  assign memSelN  = !selected;
  assign memSelP  = selected;
  assign memOeN   = (state != ST_READ);
  assign memWeN   = (state != ST_WPULSE);

  assign strobe.load    = (state == ST_IDLE) && reqValid;
  assign strobe.capture = (state == ST_READ) && phaseDone;
  assign strobe.drive   = (state == ST_WPULSE) || (state == ST_WHOLD);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              dataDrvEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rvalidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdataQ <= memDin;
      rvalidQ <= strobe.capture;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign dataDrvEn = strobe.drive;
  assign rspValid  = rvalidQ;
  assign rspRdata  = rdataQ;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_CYCLE_NS    = 15,
  parameter int T_PWE_NS      = 12,
  parameter int T_SD_NS       = 8,
  parameter int T_AW_NS       = 12,
  parameter int T_AA_NS       = 15,
  parameter int T_DOE_NS      = 8,
  parameter int T_HZOE_NS     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              dataDrvEn
);

  localparam int HZ_CYC = ns2cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int WR_CYC = max2(max2(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                               max2(ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS)));
  localparam int RD_CYC = max2(max2(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_DOE_NS, CLK_PERIOD_NS)),
                               ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int CNT_W  = $clog2(max2(max2(HZ_CYC, WR_CYC), RD_CYC) + 1);

  dp_strobe_t strobe;

  sram_ctrl_fsm #(
    .HZ_CYC(HZ_CYC),
    .WR_CYC(WR_CYC),
    .RD_CYC(RD_CYC),
    .CNT_W (CNT_W)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .memSelN (memSelN),
    .memSelP (memSelP),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .strobe  (strobe)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .dataDrvEn(dataDrvEn),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int HZ_CYC = 1,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memSelN,
  input logic              memSelP,
  input logic              memOeN,
  input logic              memWeN,
  input logic              dataDrvEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout
);

  logic [15:0] oeHighCnt, oeLowCnt, weLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeHighCnt <= '0;
      oeLowCnt  <= '0;
      weLowCnt  <= '0;
    end else begin
      oeHighCnt <= !memOeN ? '0 : ((oeHighCnt == '1) ? oeHighCnt : oeHighCnt + 16'd1);
      oeLowCnt  <= memOeN ? '0 : ((oeLowCnt == '1) ? oeLowCnt : oeLowCnt + 16'd1);
      weLowCnt  <= memWeN ? '0 : ((weLowCnt == '1) ? weLowCnt : weLowCnt + 16'd1);
    end
  end

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSelP && memOeN && memWeN && !dataDrvEn));

  p_we_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memSelN && memSelP && memOeN));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 16'(WR_CYC)));

  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memDout) && $stable(memAddr) && dataDrvEn));

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memDout) && $stable(memAddr) && dataDrvEn && !memSelN));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataDrvEn |-> (memOeN && (oeHighCnt >= 16'(HZ_CYC))));

  p_rd_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> ((oeLowCnt == 16'(RD_CYC)) && rspValid));

  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind sram_bus_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .HZ_CYC(HZ_CYC),
  .WR_CYC(WR_CYC),
  .RD_CYC(RD_CYC)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memSelN  (memSelN),
  .memSelP  (memSelP),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .dataDrvEn(dataDrvEn),
  .memAddr  (memAddr),
  .memDout  (memDout)
);

// File: tb/sram_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb_top;

  localparam int PERIOD = 8;
  localparam int T_CYC = 35, T_PWE = 20, T_SD = 12, T_AW = 25;
  localparam int T_AA = 35, T_DOE = 15, T_HZ = 10;

  function automatic int up(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_HZ = up(T_HZ);
  localparam int EXP_WR = mx(mx(up(T_PWE), up(T_SD)), mx(up(T_AW), up(T_CYC)));
  localparam int EXP_RD = mx(mx(up(T_AA), up(T_DOE)), up(T_CYC));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, memSelN, memSelP, memOeN, memWeN, dataDrvEn;
  logic [7:0]  rspRdata, memDout, memDin;
  logic [12:0] memAddr;

  always #(PERIOD/2) clk = ~clk;

  sram_bus_ctrl #(
    .CLK_PERIOD_NS(PERIOD), .T_CYCLE_NS(T_CYC), .T_PWE_NS(T_PWE), .T_SD_NS(T_SD),
    .T_AW_NS(T_AW), .T_AA_NS(T_AA), .T_DOE_NS(T_DOE), .T_HZOE_NS(T_HZ)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memSelN(memSelN), .memSelP(memSelP), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDin(memDin), .dataDrvEn(dataDrvEn)
  );

  // behavioural memory
  logic [7:0] mem [0:8191];
  wire memDrives = !memSelN && memSelP && !memOeN && memWeN;
  assign memDin = memDrives ? mem[memAddr] : 8'hxx;
  always @(posedge clk)
    if (!memSelN && memSelP && !memWeN) mem[memAddr] <= memDout;

  int oeHighRun = 0;
  always @(posedge clk)
    if (!rstN) oeHighRun <= 0;
    else oeHighRun <= memOeN ? oeHighRun + 1 : 0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(memSelN && !memSelP && memOeN && memWeN && !dataDrvEn, req,
          int'({memSelN, memSelP, memOeN, memWeN, dataDrvEn}), 'h16);
  endtask

  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    while (!reqReady) @(negedge clk);
    check_idle("R2 idle before request");
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = !wr; reqAddr = ~a; reqWdata = ~d; // R8 later changes ignored
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    int weCnt = 0;
    bit sawHold = 1'b0;
    issue(1'b1, a, d);
    for (int g = 0; g < 64 && !reqReady; g++) begin
      if (dataDrvEn)
        check(memOeN && oeHighRun >= EXP_HZ, "R6 driver after turn-off", oeHighRun, EXP_HZ);
      if (!memWeN) begin
        weCnt++;
        if (!(!memSelN && memSelP && memOeN))
          check(1'b0, "R4 select during pulse", int'({memSelN, memSelP, memOeN}), 'h3);
        if (!(memAddr == a && memDout == d && dataDrvEn))
          check(1'b0, "R5 R8 stable during pulse", int'(memDout), int'(d));
      end else if (weCnt > 0 && !sawHold) begin
        sawHold = 1'b1;
        check(memAddr == a && memDout == d && dataDrvEn && !memSelN,
              "R5 hold after pulse", int'(memDout), int'(d));
      end
      @(negedge clk);
    end
    check(weCnt == EXP_WR, "R4 pulse length", weCnt, EXP_WR);
    check(sawHold, "R5 hold cycle seen", int'(sawHold), 1);
    check_idle("R2 idle after write");
  endtask

  task automatic do_read(input logic [12:0] a, input logic [7:0] expD);
    int oeCnt = 0;
    issue(1'b0, a, 8'h00);
    for (int g = 0; g < 64 && !reqReady; g++) begin
      if (!memOeN) begin
        oeCnt++;
        if (!(memWeN && !dataDrvEn && !memSelN && memSelP && memAddr == a))
          check(1'b0, "R7 R8 read phase controls", int'({memWeN, dataDrvEn}), 'h2);
      end
      if (rspValid) check(1'b0, "R7 early valid", 1, 0);
      @(negedge clk);
    end
    check(oeCnt == EXP_RD, "R7 read length", oeCnt, EXP_RD);
    check(rspValid == 1'b1, "R7 valid after read", int'(rspValid), 1);
    check(rspRdata == expD, "R3 read data", int'(rspRdata), int'(expD));
    check_idle("R2 idle after read");
    @(negedge clk);
    check(rspValid == 1'b0, "R7 single-cycle valid", int'(rspValid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(memSelN && !memSelP && memOeN && memWeN && !dataDrvEn && reqReady && !rspValid,
          "R1 reset state", int'({memSelN, memSelP, memOeN, memWeN, dataDrvEn, reqReady, rspValid}), 'h5A);
    rstN = 1'b1;
    @(negedge clk);
    check(memSelN && !memSelP && memOeN && memWeN && !dataDrvEn && reqReady && !rspValid,
          "R1 after reset", int'({memSelN, memSelP, memOeN, memWeN, dataDrvEn, reqReady, rspValid}), 'h5A);
  endtask

  task automatic t_basic;
    do_write(13'h0123, 8'hA5);
    do_read(13'h0123, 8'hA5);
  endtask

  task automatic t_bounds; // R3 at both ends of the address range
    do_write(13'h0000, 8'h3C);
    do_write(13'h1FFF, 8'hC3);
    do_read(13'h0000, 8'h3C);
    do_read(13'h1FFF, 8'hC3);
  endtask

  task automatic t_patterns;
    for (int i = 0; i < 4; i++) do_write(13'h0100 + 13'(i), 8'(i * 8'h55 + 8'h0F));
    for (int i = 3; i >= 0; i--) do_read(13'h0100 + 13'(i), 8'(i * 8'h55 + 8'h0F));
  endtask

  task automatic t_turnaround; // R6 writes right after reads and the reverse
    do_write(13'h0055, 8'h11);
    do_read(13'h0055, 8'h11);
    do_write(13'h0055, 8'hEE);
    do_read(13'h0055, 8'hEE);
    do_write(13'h0AAA, 8'hFF);
    do_write(13'h0AAB, 8'h00);
    do_read(13'h0AAA, 8'hFF);
    do_read(13'h0AAB, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_patterns();
    t_turnaround();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * PERIOD);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule